// File: doc/BRIEF.md
# Pin Control Register File

This block holds the configuration of every pin of one I/O port. Each pin owns one 32-bit register in a word-addressed register space. The register sets the pin's pull (enable and direction), slew rate, passive filter, open-drain output, drive strength, function multiplexer select, a lock flag and a 4-bit interrupt configuration code. The decoded fields are driven continuously to the pad and interrupt logic next to the block.

Two further words above the pin registers are global write registers. One write to such a word copies a 16-bit value into the lower halves of any group of pins, chosen by a mask in the upper half of the same word. Each global word serves one bank of 16 pins. A pin's lock flag freezes the lower half of its register, which holds all electrical and function fields, until the next reset. Software can therefore fix a pin's setup for good early in boot.

Top module: `pcr_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every pin register reads zero and every field output is low. That means pull disabled, fast slew, function 0, interrupt code 0 and unlocked.
- R2: A direct write to a pin register keeps only the implemented bits: 0, 1, 2, 4, 5, 6, 10:8, 15 and 19:16 (mask 0x000F8777). Readback returns those bits, and every other bit reads zero.
- R3: Each pin's fields are driven to the outputs. Bit 0 goes to pull_up_o (1 = pull-up), bit 1 to pull_en_o, bit 2 to slew_slow_o, bit 4 to filt_en_o, bit 5 to od_en_o, bit 6 to drv_high_o, bits 10:8 to fn_sel_o, bit 15 to lock_o and bits 19:16 to irq_cfg_o.
- R4: Pin n sits at byte address 4*n. The global words sit at 0x80 (pins 0 to 15) and 0x84 (pins 16 to 31). An address with bits 1:0 not zero, or above 0x84, or 0x88 and up, is unmapped: it reads zero and a write to it changes nothing.
- R5: A write to 0x80 takes data from bits 15:0 and an enable for pin j from bit 16+j, for j from 0 to 15. Each enabled pin gets the masked data in bits 15:0. Its bits 19:16 and all pins not enabled keep their values.
- R6: A write to 0x84 has the same layout. Enable bit 16+j selects pin 16+j.
- R7: Both global words always read as zero.
- R8: Once a pin's lock bit is set, direct writes no longer change bits 15:0 of that pin until reset.
- R9: A global write skips locked pins and still updates the unlocked pins it enables.
- R10: A direct write to a locked pin still updates its interrupt code in bits 19:16.
- R11: A global write whose data has bit 15 set locks every unlocked pin it enables.
- R12: Reset clears every lock, and after reset the pins accept writes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational readback of the addressed word |
| pull_up_o | output | 32 | Per pin pull direction, 1 = up |
| pull_en_o | output | 32 | Per pin pull enable |
| slew_slow_o | output | 32 | Per pin slow slew select |
| filt_en_o | output | 32 | Per pin passive filter enable |
| od_en_o | output | 32 | Per pin open-drain enable |
| drv_high_o | output | 32 | Per pin high drive select |
| lock_o | output | 32 | Per pin configuration lock |
| fn_sel_o | output | 96 | Function select, 3 bits per pin, pin n at [3n+2:3n] |
| irq_cfg_o | output | 128 | Interrupt code, 4 bits per pin, pin n at [4n+3:4n] |

## Verification
Direct writes use all-ones data, sparse field patterns and data that sets the lock. Together these separate the masking of unimplemented bits from the field routing and from lock entry. Global writes go to both banks with scattered enable masks and include locked pins among the targets. This shows which bank a word reaches, that the enable mask selects the pins and that the interrupt code is left alone. A long run of mixed direct and global writes from a shift-register pattern, followed by reads of all 32 pins, shows that no pin picks up another pin's write once locks build up. Writes to unmapped and misaligned addresses are followed by reads that expose any side effect.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LO_W   = 16;
  localparam int unsigned IRQ_W  = 4;
  localparam int unsigned FN_W   = 3;
  localparam int unsigned GLOB_W = 16;

  localparam int unsigned B_PULL_UP = 0;
  localparam int unsigned B_PULL_EN = 1;
  localparam int unsigned B_SLEW    = 2;
  localparam int unsigned B_FILT    = 4;
  localparam int unsigned B_OD      = 5;
  localparam int unsigned B_DRV     = 6;
  localparam int unsigned B_FN      = 8;
  localparam int unsigned B_LOCK    = 15;
  localparam int unsigned B_IRQ     = 16;

  // implemented bits of the lockable lower half
  localparam logic [LO_W-1:0] LO_MASK = 16'h8777;

  typedef struct packed {
    logic [IRQ_W-1:0] irq;
    logic             lock;
    logic [FN_W-1:0]  fn;
    logic             drv;
    logic             od;
    logic             filt;
    logic             slew;
    logic             pull_en;
    logic             pull_up;
  } pin_cfg_t;

  function automatic pin_cfg_t unpack_cfg(input logic [LO_W-1:0] lo,
                                          input logic [IRQ_W-1:0] irq);
    pin_cfg_t c;
    c.irq     = irq;
    c.lock    = lo[B_LOCK];
    c.fn      = lo[B_FN +: FN_W];
    c.drv     = lo[B_DRV];
    c.od      = lo[B_OD];
    c.filt    = lo[B_FILT];
    c.slew    = lo[B_SLEW];
    c.pull_en = lo[B_PULL_EN];
    c.pull_up = lo[B_PULL_UP];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] pack_cfg(input pin_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_IRQ +: IRQ_W] = c.irq;
    w[B_LOCK]         = c.lock;
    w[B_FN +: FN_W]   = c.fn;
    w[B_DRV]          = c.drv;
    w[B_OD]           = c.od;
    w[B_FILT]         = c.filt;
    w[B_SLEW]         = c.slew;
    w[B_PULL_EN]      = c.pull_en;
    w[B_PULL_UP]      = c.pull_up;
    return w;
  endfunction
endpackage

// File: rtl/pcr_rst_sync.sv
module pcr_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/pcr_addr_dec.sv
module pcr_addr_dec #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [pcr_pkg::GLOB_W-1:0]  glob_en,
  output logic                        pin_hit,
  output logic [$clog2(NUM_PINS)-1:0] pin_sel,
  output logic [NUM_PINS-1:0]         dir_we,
  output logic [NUM_PINS-1:0]         glob_we
);
  import pcr_pkg::*;

  localparam int unsigned WIDX_W    = ADDR_W - 2;
  localparam int unsigned SEL_W     = $clog2(NUM_PINS);
  localparam int unsigned NUM_BANKS = NUM_PINS / GLOB_W;
  localparam logic [WIDX_W-1:0] PIN_END = WIDX_W'(NUM_PINS);

  logic [WIDX_W-1:0]    widx;
  logic                 aligned;
  logic [NUM_BANKS-1:0] bank_hit;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign pin_hit = aligned && (widx < PIN_END);
  assign pin_sel = widx[SEL_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_hit[b] = aligned && (widx == WIDX_W'(NUM_PINS + b));
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_we
    assign dir_we[i]  = bus_wr && pin_hit && (pin_sel == SEL_W'(i));
    assign glob_we[i] = bus_wr && bank_hit[i / GLOB_W] && glob_en[i % GLOB_W];
  end
endmodule

// File: rtl/pcr_pin_reg.sv
module pcr_pin_reg (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dir_we,
  input  logic                       glob_we,
  input  logic [pcr_pkg::LO_W-1:0]   lo_data,
  input  logic [pcr_pkg::IRQ_W-1:0]  irq_data,
  output pcr_pkg::pin_cfg_t          cfg_o
);
  import pcr_pkg::*;

  logic [LO_W-1:0]  lo_q,  lo_d;
  logic [IRQ_W-1:0] irq_q, irq_d;
  logic             lo_en, irq_en;

  // next state: lower half frozen by the lock, interrupt code only by direct write
  always_comb begin
    lo_en  = (dir_we || glob_we) && !lo_q[B_LOCK];
    irq_en = dir_we;
    lo_d   = lo_data & LO_MASK;
    irq_d  = irq_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      irq_q <= '0;
    end else begin
      if (lo_en)  lo_q  <= lo_d;
      if (irq_en) irq_q <= irq_d;
    end
  end

  assign cfg_o = unpack_cfg(lo_q, irq_q);
endmodule

// File: rtl/pcr_bank.sv
module pcr_bank #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 bus_wr,
  input  logic [ADDR_W-1:0]                    bus_addr,
  input  logic [pcr_pkg::WORD_W-1:0]           bus_wdata,
  output logic [pcr_pkg::WORD_W-1:0]           bus_rdata,
  output logic [NUM_PINS-1:0]                  pull_up_o,
  output logic [NUM_PINS-1:0]                  pull_en_o,
  output logic [NUM_PINS-1:0]                  slew_slow_o,
  output logic [NUM_PINS-1:0]                  filt_en_o,
  output logic [NUM_PINS-1:0]                  od_en_o,
  output logic [NUM_PINS-1:0]                  drv_high_o,
  output logic [NUM_PINS-1:0]                  lock_o,
  output logic [NUM_PINS*pcr_pkg::FN_W-1:0]    fn_sel_o,
  output logic [NUM_PINS*pcr_pkg::IRQ_W-1:0]   irq_cfg_o
);
  import pcr_pkg::*;

  localparam int unsigned SEL_W = $clog2(NUM_PINS);

  logic              rst_n_s;
  logic              pin_hit;
  logic [SEL_W-1:0]  pin_sel;
  logic [NUM_PINS-1:0] dir_we, glob_we;
  pin_cfg_t          cfg [NUM_PINS];

  pcr_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  pcr_addr_dec #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dec (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .glob_en  (bus_wdata[WORD_W-1:LO_W]),
    .pin_hit  (pin_hit),
    .pin_sel  (pin_sel),
    .dir_we   (dir_we),
    .glob_we  (glob_we)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pcr_pin_reg u_pin (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .dir_we   (dir_we[i]),
      .glob_we  (glob_we[i]),
      .lo_data  (bus_wdata[LO_W-1:0]),
      .irq_data (bus_wdata[B_IRQ +: IRQ_W]),
      .cfg_o    (cfg[i])
    );

    assign pull_up_o[i]   = cfg[i].pull_up;
    assign pull_en_o[i]   = cfg[i].pull_en;
    assign slew_slow_o[i] = cfg[i].slew;
    assign filt_en_o[i]   = cfg[i].filt;
    assign od_en_o[i]     = cfg[i].od;
    assign drv_high_o[i]  = cfg[i].drv;
    assign lock_o[i]      = cfg[i].lock;
    assign fn_sel_o[i*FN_W +: FN_W]    = cfg[i].fn;
    assign irq_cfg_o[i*IRQ_W +: IRQ_W] = cfg[i].irq;
  end

  // global words and unmapped space read zero
  always_comb begin
    bus_rdata = '0;
    if (pin_hit) bus_rdata = pack_cfg(cfg[pin_sel]);
  end
endmodule

// File: rtl/pcr_bank_chk.sv
module pcr_bank_chk #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 bus_wr,
  input logic [ADDR_W-1:0]                    bus_addr,
  input logic [pcr_pkg::WORD_W-1:0]           bus_wdata,
  input logic [pcr_pkg::WORD_W-1:0]           bus_rdata,
  input logic [NUM_PINS-1:0]                  pull_up_o,
  input logic [NUM_PINS-1:0]                  pull_en_o,
  input logic [NUM_PINS-1:0]                  slew_slow_o,
  input logic [NUM_PINS-1:0]                  filt_en_o,
  input logic [NUM_PINS-1:0]                  od_en_o,
  input logic [NUM_PINS-1:0]                  drv_high_o,
  input logic [NUM_PINS-1:0]                  lock_o,
  input logic [NUM_PINS*pcr_pkg::FN_W-1:0]    fn_sel_o,
  input logic [NUM_PINS*pcr_pkg::IRQ_W-1:0]   irq_cfg_o
);
  import pcr_pkg::*;

  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam int unsigned SEL_W  = $clog2(NUM_PINS);
  localparam logic [WIDX_W-1:0] PIN_END = WIDX_W'(NUM_PINS);

  logic             is_pin;
  logic [SEL_W-1:0] sel;
  assign is_pin = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:2] < PIN_END);
  assign sel    = bus_addr[SEL_W+1:2];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (lock_o == '0 && fn_sel_o == '0 && irq_cfg_o == '0 && pull_en_o == '0));

  // R2
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~32'h000F_8777) == '0);

  // R7
  glob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_pin |-> bus_rdata == '0);

  // R3
  field_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pin |-> (bus_rdata[B_FN +: FN_W] == fn_sel_o[sel*FN_W +: FN_W] &&
                bus_rdata[B_IRQ +: IRQ_W] == irq_cfg_o[sel*IRQ_W +: IRQ_W] &&
                bus_rdata[B_LOCK] == lock_o[sel]));

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_o & $past(lock_o)) == $past(lock_o)));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_lk
    // R8
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_o[i] |=> ($stable(fn_sel_o[i*FN_W +: FN_W]) && $stable(pull_up_o[i]) &&
                     $stable(pull_en_o[i]) && $stable(slew_slow_o[i]) &&
                     $stable(filt_en_o[i]) && $stable(od_en_o[i]) && $stable(drv_high_o[i])));
  end

  logic unused_ok;
  assign unused_ok = ^{bus_wr, bus_wdata};
endmodule

bind pcr_bank pcr_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_pcr_bank.sv
module test_pcr_bank;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MASK = 32'h000F_8777;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pull_up_o, pull_en_o, slew_slow_o, filt_en_o, od_en_o, drv_high_o, lock_o;
  logic [95:0]  fn_sel_o;
  logic [127:0] irq_cfg_o;

  pcr_bank i_pcr_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pull_up_o(pull_up_o), .pull_en_o(pull_en_o), .slew_slow_o(slew_slow_o),
    .filt_en_o(filt_en_o), .od_en_o(od_en_o), .drv_high_o(drv_high_o),
    .lock_o(lock_o), .fn_sel_o(fn_sel_o), .irq_cfg_o(irq_cfg_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  rd_item_t    sb_q[$];
  logic [31:0] mdl [32];
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected readbacks and compares away from the clock edge
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (sb_q.size() > 0) begin
      rd_item_t it;
      it = sb_q.pop_front();
      check(it.tag, bus_rdata, it.exp, $sformatf("read @%02h", it.addr));
    end
  end

  function automatic void mdl_apply(input logic [7:0] a, input logic [31:0] d);
    int w;
    if (a[1:0] != 2'b00) return;
    w = int'(a[7:2]);
    if (w < 32) begin
      mdl[w][19:16] = d[19:16];
      if (!mdl[w][15]) mdl[w][15:0] = d[15:0] & MASK[15:0];
    end else if (w == 32 || w == 33) begin
      for (int j = 0; j < 16; j++) begin
        int p;
        p = (w - 32) * 16 + j;
        if (d[16+j] && !mdl[p][15]) mdl[p][15:0] = d[15:0] & MASK[15:0];
      end
    end
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    mdl_apply(a, d);
  endtask

  task automatic bus_read(input logic [7:0] a, input string tag);
    rd_item_t it;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    it.addr = a;
    it.exp  = (a[1:0] == 2'b00 && a[7:2] < 6'd32) ? mdl[a[7:2]] : 32'h0;
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  task automatic check_pin_out(input int i, input string tag);
    logic [31:0] act, exp;
    act = {18'h0, irq_cfg_o[i*4 +: 4], lock_o[i], fn_sel_o[i*3 +: 3], drv_high_o[i],
           od_en_o[i], filt_en_o[i], slew_slow_o[i], pull_en_o[i], pull_up_o[i]};
    exp = {18'h0, mdl[i][19:16], mdl[i][15], mdl[i][10:8], mdl[i][6], mdl[i][5],
           mdl[i][4], mdl[i][2], mdl[i][1], mdl[i][0]};
    check(tag, act, exp, $sformatf("outputs pin %0d", i));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    @(negedge clk);
    // R1: state while reset is held
    check("R1", lock_o | pull_en_o | pull_up_o, 32'h0, "outputs in reset");
    do_reset();
    // R1: after release
    bus_read(8'h00, "R1");
    bus_read(8'h7C, "R1");
    check("R1", fn_sel_o[31:0] | irq_cfg_o[31:0] | drv_high_o, 32'h0, "outputs after reset");

    // R2, R3: all-ones except lock
    bus_write(8'h0C, 32'hFFFF_7FFF);
    bus_read(8'h0C, "R2");
    check_pin_out(3, "R3");
    // R2, R3: sparse fields
    bus_write(8'h14, 32'h0003_0245);
    bus_read(8'h14, "R2");
    check_pin_out(5, "R3");

    // R4: unmapped and misaligned writes change nothing
    bus_write(8'h88, 32'hFFFF_FFFF);
    bus_write(8'h01, 32'h0000_0777);
    bus_write(8'hFC, 32'hFFFF_FFFF);
    bus_read(8'h00, "R4");
    bus_read(8'h0C, "R4");
    bus_read(8'h88, "R4");
    bus_read(8'h0D, "R4");
    bus_read(8'hFC, "R4");

    // R5: global low, enables pins 0,2,5,7
    bus_write(8'h80, 32'h00A5_0123);
    bus_read(8'h00, "R5");
    bus_read(8'h04, "R5");
    bus_read(8'h08, "R5");
    bus_read(8'h14, "R5");
    bus_read(8'h1C, "R5");
    bus_read(8'h40, "R5");
    check_pin_out(5, "R5");
    // R7
    bus_read(8'h80, "R7");
    bus_read(8'h84, "R7");

    // R6: global high, enables pins 16 and 31
    bus_write(8'h84, 32'h8001_0444);
    bus_read(8'h40, "R6");
    bus_read(8'h44, "R6");
    bus_read(8'h7C, "R6");
    bus_read(8'h00, "R6");
    check_pin_out(31, "R6");

    // R8: lock pin 9, then try to change it
    bus_write(8'h24, 32'h0000_8001);
    bus_write(8'h24, 32'h0000_0012);
    bus_read(8'h24, "R8");
    check_pin_out(9, "R8");
    // R10: interrupt code still writable
    bus_write(8'h24, 32'h0005_0777);
    bus_read(8'h24, "R10");
    check_pin_out(9, "R10");
    // R9: global hits pins 0 and 9, pin 9 locked
    bus_write(8'h80, 32'h0201_0033);
    bus_read(8'h00, "R9");
    bus_read(8'h24, "R9");
    // R11: global write sets lock on pin 17
    bus_write(8'h84, 32'h0002_8004);
    bus_write(8'h44, 32'h0000_0000);
    bus_read(8'h44, "R11");
    check_pin_out(17, "R11");

    // mixed traffic from a shift-register pattern
    lfsr = 16'hACE1;
    for (int k = 0; k < 60; k++) begin
      logic [7:0] a;
      logic [31:0] d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      d = {lfsr ^ 16'h5A3C, lfsr};
      if (lfsr[3:0] == 4'd0) a = 8'h80;
      else if (lfsr[3:0] == 4'd1) a = 8'h84;
      else a = {1'b0, lfsr[9:5], 2'b00};
      if (lfsr[15:14] == 2'b11) d[15] = 1'b1; else d[15] = 1'b0;
      bus_write(a, d);
    end
    for (int i = 0; i < 32; i++) begin
      bus_read(8'(i * 4), "R9");
      check_pin_out(i, "R3");
    end

    // R12: reset clears locks
    do_reset();
    bus_read(8'h24, "R12");
    bus_read(8'h44, "R12");
    bus_write(8'h24, 32'h0000_0002);
    bus_read(8'h24, "R12");
    check("R12", lock_o, 32'h0, "locks after reset");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule